// File: doc/BRIEF.md
# Multi-Die Test Access Router

This block sits on the host die of a multi-die package. It takes the package's single external test access port (clock, mode select, data in, data out and an active-low test reset) and routes it to N die-side test ports. Each die-side port has a mode-select output, a data-in output and a data-out input. All dies share the test clock. The router follows the standard 16-state test access state machine on the external port. Its own instruction register is always the first stage of the instruction path.

The router has two routings and switches between them at run time. In star routing, one selected die is connected directly to the external data pins, so that single die can be tested while the package is being assembled. Every other die receives a constant-high mode select and stays in its logic reset state. In ring routing, all dies are daisy-chained, so the package looks like one device to its end user. In that routing, the identification instruction returns one 32-bit package code, which is the host die's code, with all dies cut out of the path. A private routing instruction carries the requested routing and die number. The request takes effect only when the state machine next enters Update-IR or Run-Test/Idle.

Top module: `pkg_tap_router`

## Requirements
- R1: While `trst_n` is low at a rising `tck` edge, the router returns to ring routing, die 0, the identification instruction, and `tdo_oe` low.
- R2: Five consecutive rising `tck` edges with `tms` high give the same reset as R1, without `trst_n`.
- R3: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is high only while the external state machine is in Shift-DR or Shift-IR.
- R4: In ring routing, the instruction path is the router's 4-bit instruction register (nearest `tdi`), then die 0, die 1, up to die N-1, then `tdo`. Capture-IR loads binary 0001 into the router register, which is shifted least significant bit first.
- R5: In ring routing, under any instruction other than 0001 and 1010, the data path is `tdi`, then die 0 through die N-1, then `tdo`. Every `die_tms` bit follows `tms`.
- R6: In ring routing, instruction 0001 (identification) puts only the router's 32-bit package code `PKG_IDCODE` between `tdi` and `tdo`, least significant bit first. After 32 shifts, the `tdi` data appears at `tdo`.
- R7: Instruction 1010 (routing) selects a 3-bit data register. Bit 0 is the routing (1 = star, 0 = ring). Bits 2:1 are the die number. Capture-DR loads the routing currently in force, and Update-DR records the shifted value as a pending request.
- R8: A pending request takes effect only on entry to Update-IR or Run-Test/Idle, never in any other state.
- R9: In star routing, the selected die gets `tms` and `tdi`, and its `tdo` drives the external `tdo`. Every other die has `die_tms` held at 1.
- R10: In star routing, the identification instruction does not use the router's code. The data path runs through the selected die only.
- R11: A routing request whose die number is N or more is discarded at Update-DR. The routing in force and the pending request stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | External test clock, shared by all dies |
| trst_n | input | 1 | External test reset, active low, sampled on rising `tck` |
| tms | input | 1 | External mode select |
| tdi | input | 1 | External serial data in |
| tdo | output | 1 | External serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo`; high only while shifting |
| die_tms | output | N_DIES | Mode select to each die |
| die_tdi | output | N_DIES | Serial data in to each die |
| die_tdo | input | N_DIES | Serial data out from each die |

## Verification
A wrong routing state shows up at the ports in two ways. With `tms` low, `die_tms` shows the wrong pattern in the same half-cycle. During a data shift, `tdo` shows the wrong delay from `tdi`: one bit per die for star, N bits for ring, or 32 bits under identification in ring routing. A wrong instruction or capture value appears within the first few shifted bits of the next scan. A routing change applied too early shows a star `die_tms` pattern while the state machine is still in Select-DR. Reading back the routing register confirms whether an out-of-range die number was discarded.

// File: rtl/tapr_pkg.sv
// Package: shared types for the multi-die test access router.
// Holds the 16-state test access state machine encoding, the routing
// mode type and the next-state function used by the state tracker.
package tapr_pkg;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SEL_DR  = 4'd2,
        ST_CAP_DR  = 4'd3,
        ST_SH_DR   = 4'd4,
        ST_EX1_DR  = 4'd5,
        ST_PAU_DR  = 4'd6,
        ST_EX2_DR  = 4'd7,
        ST_UPD_DR  = 4'd8,
        ST_SEL_IR  = 4'd9,
        ST_CAP_IR  = 4'd10,
        ST_SH_IR   = 4'd11,
        ST_EX1_IR  = 4'd12,
        ST_PAU_IR  = 4'd13,
        ST_EX2_IR  = 4'd14,
        ST_UPD_IR  = 4'd15
    } tap_state_e;

    typedef enum logic {
        ROUTE_RING = 1'b0,
        ROUTE_STAR = 1'b1
    } route_mode_e;

    // Next state of the test access state machine for a given mode select.
    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tapr_fsm.sv
// Module: tapr_fsm
// Tracks the external test access state machine on tck/tms.
// Assumes trst_n is sampled synchronously on the rising tck edge.
// Exposes both the current state and the state it will take next,
// so that other logic can act on entry into a state.
module tapr_fsm
    import tapr_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q,
    output tap_state_e state_nx
);

    // Next-state decode from the shared table.
    always_comb begin
        state_nx = tap_next(state_q, tms);
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_nx;
        end
    end

    // R2: five rising edges with tms high always land in the reset state.
    assert_five_ones_reset_R2: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> (state_q == ST_RESET));

endmodule

// File: rtl/tapr_ctrl.sv
// Module: tapr_ctrl
// Router-owned registers: the instruction register, the 32-bit package
// code register and the routing register, plus the routing in force and
// the pending routing request. Assumes the state inputs come from
// tapr_fsm on the same clock. A request is applied only on entry into
// Update-IR or Run-Test/Idle, so no chain is cut during a shift.
module tapr_ctrl
    import tapr_pkg::*;
#(
    parameter int          N_DIES     = 3,
    parameter int          SEL_W      = 2,
    parameter int          IR_W       = 4,
    parameter logic [31:0] PKG_IDCODE = 32'h4C7A_E02B,
    parameter logic [3:0]  OP_IDCODE  = 4'b0001,
    parameter logic [3:0]  OP_ROUTE   = 4'b1010
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  tap_state_e        state_q,
    input  tap_state_e        state_nx,
    output route_mode_e       mode_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic              ir_out,
    output logic              own_dr,
    output logic              own_dr_bit
);

    localparam int              RT_W       = SEL_W + 1;
    localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);
    localparam logic [IR_W-1:0] IR_ID      = IR_W'(OP_IDCODE);
    localparam logic [IR_W-1:0] IR_RT      = IR_W'(OP_ROUTE);
    localparam logic [SEL_W:0]  SEL_LIMIT  = (SEL_W + 1)'(N_DIES);

    logic [IR_W-1:0]  ir_sh;
    logic [IR_W-1:0]  ir_q;
    logic [31:0]      id_sh;
    logic [RT_W-1:0]  rt_sh;
    logic [RT_W-1:0]  pend_q;
    logic [RT_W-1:0]  pend_nx;
    logic             is_id;
    logic             is_rt;
    logic             wr_route;
    logic             apply;
    logic             soft_rst;

    // Decode of the active instruction and of the write/apply events.
    always_comb begin
        is_id    = (ir_q == IR_ID);
        is_rt    = (ir_q == IR_RT);
        soft_rst = !trst_n || (state_q == ST_RESET);
        wr_route = is_rt && (state_q == ST_UPD_DR) &&
                   ({1'b0, rt_sh[RT_W-1:1]} < SEL_LIMIT);
        pend_nx  = wr_route ? rt_sh : pend_q;
        apply    = (state_nx == ST_UPD_IR) || (state_nx == ST_IDLE);
    end

    // Instruction shift stage: capture the fixed pattern, shift toward tdo.
    always_ff @(posedge tck) begin
        if (soft_rst) begin
            ir_sh <= IR_CAPTURE;
        end else if (state_q == ST_CAP_IR) begin
            ir_sh <= IR_CAPTURE;
        end else if (state_q == ST_SH_IR) begin
            ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        end
    end

    // Package code data register: load on capture, shift under identification.
    always_ff @(posedge tck) begin
        if (soft_rst) begin
            id_sh <= PKG_IDCODE;
        end else if (is_id && state_q == ST_CAP_DR) begin
            id_sh <= PKG_IDCODE;
        end else if (is_id && state_q == ST_SH_DR) begin
            id_sh <= {tdi, id_sh[31:1]};
        end
    end

    // Routing data register: capture the routing in force, then shift.
    always_ff @(posedge tck) begin
        if (soft_rst) begin
            rt_sh <= '0;
        end else if (is_rt && state_q == ST_CAP_DR) begin
            rt_sh <= {sel_q, mode_q};
        end else if (is_rt && state_q == ST_SH_DR) begin
            rt_sh <= {tdi, rt_sh[RT_W-1:1]};
        end
    end

    // Instruction, pending request and routing in force.
    always_ff @(posedge tck) begin
        if (soft_rst) begin
            ir_q   <= IR_ID;
            pend_q <= '0;
            mode_q <= ROUTE_RING;
            sel_q  <= '0;
        end else begin
            if (state_q == ST_UPD_IR) begin
                ir_q <= ir_sh;
            end
            pend_q <= pend_nx;
            if (apply) begin
                mode_q <= route_mode_e'(pend_nx[0]);
                sel_q  <= pend_nx[RT_W-1:1];
            end
        end
    end

    // Outputs toward the routing fabric.
    always_comb begin
        ir_out     = ir_sh[0];
        own_dr     = is_rt || (is_id && mode_q == ROUTE_RING);
        own_dr_bit = is_rt ? rt_sh[0] : id_sh[0];
    end

    // R8: the routing in force changes only in Update-IR, Run-Test/Idle or reset.
    assert_cfg_switch_point_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (!$stable(mode_q) || !$stable(sel_q)) |->
        (state_q == ST_UPD_IR || state_q == ST_IDLE || state_q == ST_RESET));

    // R11: the selected die number never leaves the valid range.
    assert_sel_in_range_R11: assert property (@(posedge tck) disable iff (!trst_n)
        ({1'b0, sel_q} < SEL_LIMIT));

endmodule

// File: rtl/tapr_route.sv
// Module: tapr_route
// Combinational fabric that steers mode select and serial data to the
// dies and picks the source for external tdo. Assumes die data outputs
// are stable around the falling tck edge. Ring routing chains die k-1
// into die k; star routing feeds only the selected die and parks the rest.
module tapr_route
    import tapr_pkg::*;
#(
    parameter int N_DIES = 3,
    parameter int SEL_W  = 2
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    input  tap_state_e        state_q,
    input  route_mode_e       mode_q,
    input  logic [SEL_W-1:0]  sel_q,
    input  logic              ir_out,
    input  logic              own_dr,
    input  logic              own_dr_bit,
    input  logic [N_DIES-1:0] die_tdo,
    output logic [N_DIES-1:0] die_tms,
    output logic [N_DIES-1:0] die_tdi,
    output logic              tdo_src
);

    logic head;
    logic chain_end;
    logic ring;

    // Chain head: router instruction stage during Shift-IR, else external tdi.
    always_comb begin
        ring = (mode_q == ROUTE_RING);
        head = (state_q == ST_SH_IR) ? ir_out : tdi;
    end

    // Per-die steering of mode select and data in.
    for (genvar k = 0; k < N_DIES; k++) begin : g_die
        assign die_tms[k] = (!ring && sel_q != SEL_W'(k)) ? 1'b1 : tms;
        if (k == 0) begin : g_first
            assign die_tdi[k] = head;
        end else begin : g_rest
            assign die_tdi[k] = ring ? die_tdo[k-1] : head;
        end
    end

    // Chain end: last die in ring, the selected die in star.
    always_comb begin
        chain_end = die_tdo[N_DIES-1];
        if (!ring) begin
            chain_end = 1'b1;
            for (int k = 0; k < N_DIES; k++) begin
                if (sel_q == SEL_W'(k)) begin
                    chain_end = die_tdo[k];
                end
            end
        end
    end

    // External data source: router register when it owns the data path.
    always_comb begin
        tdo_src = (state_q == ST_SH_DR && own_dr) ? own_dr_bit : chain_end;
    end

    // R9: in star routing at most one die follows tms, and it is the selected one.
    assert_star_parks_others_R9: assert property (@(posedge tck) disable iff (!trst_n)
        (mode_q == ROUTE_STAR) |->
        (($countones(~die_tms) <= 1) && ($countones(die_tms) >= N_DIES - 1)));

endmodule

// File: rtl/pkg_tap_router.sv
// Module: pkg_tap_router (top)
// Routes one external test access port to N die-side ports in star or
// ring routing. Assumes all dies share tck and that the host die's
// identification code is given as PKG_IDCODE (least significant bit 1).
// External tdo and its enable are retimed to the falling tck edge.
module pkg_tap_router
    import tapr_pkg::*;
#(
    parameter int          N_DIES     = 3,
    parameter int          IR_W       = 4,
    parameter logic [31:0] PKG_IDCODE = 32'h4C7A_E02B,
    parameter logic [3:0]  OP_IDCODE  = 4'b0001,
    parameter logic [3:0]  OP_ROUTE   = 4'b1010
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_oe,
    output logic [N_DIES-1:0] die_tms,
    output logic [N_DIES-1:0] die_tdi,
    input  logic [N_DIES-1:0] die_tdo
);

    localparam int SEL_W = (N_DIES > 1) ? $clog2(N_DIES) : 1;

    tap_state_e        state_q;
    tap_state_e        state_nx;
    route_mode_e       mode_q;
    logic [SEL_W-1:0]  sel_q;
    logic              ir_out;
    logic              own_dr;
    logic              own_dr_bit;
    logic              tdo_src;

    tapr_fsm u_fsm (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .state_q  (state_q),
        .state_nx (state_nx)
    );

    tapr_ctrl #(
        .N_DIES     (N_DIES),
        .SEL_W      (SEL_W),
        .IR_W       (IR_W),
        .PKG_IDCODE (PKG_IDCODE),
        .OP_IDCODE  (OP_IDCODE),
        .OP_ROUTE   (OP_ROUTE)
    ) u_ctrl (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .state_q    (state_q),
        .state_nx   (state_nx),
        .mode_q     (mode_q),
        .sel_q      (sel_q),
        .ir_out     (ir_out),
        .own_dr     (own_dr),
        .own_dr_bit (own_dr_bit)
    );

    tapr_route #(
        .N_DIES (N_DIES),
        .SEL_W  (SEL_W)
    ) u_route (
        .tck        (tck),
        .trst_n     (trst_n),
        .tms        (tms),
        .tdi        (tdi),
        .state_q    (state_q),
        .mode_q     (mode_q),
        .sel_q      (sel_q),
        .ir_out     (ir_out),
        .own_dr     (own_dr),
        .own_dr_bit (own_dr_bit),
        .die_tdo    (die_tdo),
        .die_tms    (die_tms),
        .die_tdi    (die_tdi),
        .tdo_src    (tdo_src)
    );

    // Falling-edge retiming of external data out and its enable.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b1;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= tdo_src;
            tdo_oe <= (state_q == ST_SH_DR) || (state_q == ST_SH_IR);
        end
    end

    // R3: the output enable is seen high only inside a shift state.
    assert_oe_only_shift_R3: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state_q == ST_SH_DR || state_q == ST_SH_IR));

endmodule

// File: tb/pkg_tap_router_bench.sv
module pkg_tap_router_bench;

    localparam int          N      = 3;
    localparam int          TCK_NS = 20;
    localparam logic [31:0] PKG_ID = 32'h4C7A_E02B;
    localparam logic [3:0]  OP_ID  = 4'b0001;
    localparam logic [3:0]  OP_RT  = 4'b1010;

    logic         tck = 1'b0;
    logic         trst_n = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic         tdo;
    logic         tdo_oe;
    logic [N-1:0] die_tms;
    logic [N-1:0] die_tdi;
    logic [N-1:0] die_tdo;
    logic [N-1:0] dmod = '0;

    int           n_chk = 0;
    int           n_err = 0;
    logic         tdo_pos;
    logic [63:0]  din;
    logic [63:0]  dout;
    bit           cur_star = 1'b0;
    int           cur_sel = 0;

    always #(TCK_NS/2) tck = ~tck;

    // Each bench die is a one-bit bypass stage.
    always_ff @(posedge tck) dmod <= die_tdi;
    assign die_tdo = dmod;

    pkg_tap_router #(.N_DIES(N), .PKG_IDCODE(PKG_ID)) u_pkg_tap_router (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .tdo_oe(tdo_oe), .die_tms(die_tms), .die_tdi(die_tdi), .die_tdo(die_tdo)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_tms_low(input bit star, input int sel);
        return star ? ~(N'(1) << sel) : '0;
    endfunction

    function automatic int pass_delay(input bit star);
        return star ? 1 : N;
    endfunction

    task automatic tick(input logic t, input logic d);
        tms = t;
        tdi = d;
        @(posedge tck);
        #2;
        tdo_pos = tdo;
        @(negedge tck);
        #2;
    endtask

    task automatic check_pattern(input string req);
        tms = 1'b0;
        #1;
        chk(die_tms == exp_tms_low(cur_star, cur_sel), req, 64'(die_tms), 64'(exp_tms_low(cur_star, cur_sel)));
        tms = 1'b1;
        #1;
        chk(die_tms == '1, req, 64'(die_tms), 64'({N{1'b1}}));
    endtask

    // From Run-Test/Idle: shift len bits of din, fill dout, end in Idle or Select-DR.
    task automatic shift_dr(input int len, input bit to_sel);
        bit oe_ok = 1'b1;
        bit st_ok = 1'b1;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < len; i++) begin
            if (tdo_oe !== 1'b1) oe_ok = 1'b0;
            dout[i] = tdo;
            tick(i == len - 1, din[i]);
            if (i < len - 1 && tdo_pos !== dout[i]) st_ok = 1'b0;
        end
        chk(oe_ok, "R3 enable high in Shift-DR", 64'(oe_ok), 64'd1);
        chk(st_ok, "R3 tdo steady across rising edge", 64'(st_ok), 64'd1);
        chk(tdo_oe == 1'b0, "R3 enable low after shift", 64'(tdo_oe), 64'd0);
        tick(1, 0);
        tick(to_sel, 0);
    endtask

    // From Run-Test/Idle: load code into the router instruction, check capture.
    task automatic shift_ir(input logic [3:0] code, input int pad, input string req);
        int len = pad + 4;
        logic [3:0] cap;
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < len; i++) begin
            dout[i] = tdo;
            tick(i == len - 1, (i < pad) ? 1'b1 : code[i - pad]);
        end
        chk(tdo_oe == 1'b0, "R3 enable low after Shift-IR", 64'(tdo_oe), 64'd0);
        tick(1, 0);
        tick(0, 0);
        for (int k = 0; k < 4; k++) cap[k] = dout[pad + k];
        chk(cap == 4'b0001, req, 64'(cap), 64'd1);
    endtask

    task automatic check_pass(input int len, input bit star, input string req);
        int d = pass_delay(star);
        int bad = 0;
        for (int i = d; i < len; i++) if (dout[i] !== din[i - d]) bad++;
        chk(bad == 0, req, dout, din << d);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge tck);
        #2;
        chk(tdo_oe == 1'b0, "R1 enable low in reset", 64'(tdo_oe), 64'd0);
        trst_n = 1'b1;

        // R1: reset state is ring, identification instruction.
        tick(0, 0);
        check_pattern("R1 ring pattern after reset");
        din = {$urandom, $urandom};
        shift_dr(40, 0);
        chk(dout[31:0] == PKG_ID, "R1 R6 package code", 64'(dout[31:0]), 64'(PKG_ID));
        chk(dout[39:32] == din[7:0], "R6 dies excluded in identification", 64'(dout[39:32]), 64'(din[7:0]));

        // R4 and R5: ring instruction chain, then pass-through data chain.
        shift_ir(4'b0110, N, "R4 ring capture position");
        din = {$urandom, $urandom};
        shift_dr(30, 0);
        check_pass(30, 1'b0, "R5 ring data chain");
        check_pattern("R5 all dies follow tms");

        // R7 and R8: request star die 2, leave Update-DR toward Select-DR.
        shift_ir(OP_RT, N, "R4 capture before routing");
        din = 64'b101;
        shift_dr(3, 1);
        chk(dout[2:0] == 3'b000, "R7 capture of ring die 0", 64'(dout[2:0]), 64'd0);
        check_pattern("R8 no change in Select-DR");
        tick(1, 0); tick(0, 0); tick(1, 0); tick(1, 0);
        cur_star = 1'b1; cur_sel = 2;
        check_pattern("R8 applied on Update-IR entry");
        tick(0, 0);

        // R10 and R9: identification in star passes through the selected die.
        din = {$urandom, $urandom};
        shift_dr(20, 0);
        check_pass(20, 1'b1, "R10 star identification passes to die");

        // R11: out-of-range die number is discarded.
        shift_ir(OP_RT, 1, "R4 star capture position");
        din = 64'b110;
        shift_dr(3, 0);
        chk(dout[2:0] == 3'b101, "R7 capture star die 2", 64'(dout[2:0]), 64'b101);
        check_pattern("R11 routing unchanged");
        din = 64'b011;
        shift_dr(3, 0);
        chk(dout[2:0] == 3'b101, "R11 readback after discard", 64'(dout[2:0]), 64'b101);
        cur_sel = 1;
        check_pattern("R9 star die 1 pattern");

        // Random routings, each followed by a pass-through scan.
        for (int it = 0; it < 12; it++) begin
            int  s = $urandom_range(0, N - 1);
            bit  m = 1'($urandom_range(0, 1));
            logic [3:0] code = 4'($urandom_range(2, 9));
            shift_ir(OP_RT, pass_delay(cur_star), "R4 capture in random loop");
            din = 64'({2'(s), m});
            shift_dr(3, 0);
            chk(dout[2:0] == {2'(cur_sel), cur_star}, "R7 random readback",
                64'(dout[2:0]), 64'({2'(cur_sel), cur_star}));
            cur_star = m; cur_sel = s;
            check_pattern(m ? "R9 random star pattern" : "R5 random ring pattern");
            shift_ir(code, pass_delay(cur_star), "R4 capture before pass");
            din = {$urandom, $urandom};
            shift_dr(24, 0);
            check_pass(24, cur_star, m ? "R9 random star data path" : "R5 random ring data path");
        end

        // R2: five tms-high edges reset the routing without trst_n.
        shift_ir(OP_RT, pass_delay(cur_star), "R4 capture before R2");
        din = 64'b011;
        shift_dr(3, 0);
        cur_star = 1'b1; cur_sel = 1;
        check_pattern("R2 star set before reset");
        repeat (5) tick(1, 0);
        tick(0, 0);
        cur_star = 1'b0; cur_sel = 0;
        check_pattern("R2 ring after tms reset");
        din = {$urandom, $urandom};
        shift_dr(36, 0);
        chk(dout[31:0] == PKG_ID, "R2 identification restored", 64'(dout[31:0]), 64'(PKG_ID));

        report();
        $finish;
    end

endmodule